// File: doc/BRIEF.md
# Supply-Loss Write Guard for a Battery-Backed SRAM

This block sits between a host bus and a battery-backed static memory array. It watches three digital supply-level flags (supply above the upper trip point, supply above the lower trip point, supply above the battery switchover level) and decides when the array may be accessed. When the supply sags, it waits a bounded, parameterised number of clock cycles and then write-protects and deselects the array. When the supply drops further, it selects the battery. When power comes back, it holds the array off for a long recovery period before host accesses are honoured again.

The host chip-enable, output-enable and write-enable strobes (all active low) are decoded into four access modes. From the mode that is in force, the block produces gated array strobes and a data-drive enable. Each supply flag first passes a two-flop synchronizer and a debounce filter. All timing is counted in clock cycles set by parameters. A status output reports the supervisor state.

Top module: `supply_guard`

## Requirements
- R1: After reset the status is normal (0), write-protect and battery-select are low, and the array strobes follow the host decode.
- R2: Mode decode, with code values on `mode_o`. Host E high gives deselect (0): array enable inactive and no data drive. E low with W low gives write (3). E low, G low and W high gives read (1), with `dq_oe_o` high. E low with G and W high gives outputs-off (2).
- R3: A read turns into a write, and `dq_oe_o` drops, in the same cycle that W goes low while E and G are low.
- R4: The array write strobe is low exactly while both host E and host W are low. The write therefore opens at the later falling edge and closes at the earlier rising edge.
- R5: A level flag that differs from its filtered value for fewer than `DEB_CYC` consecutive cycles has no effect.
- R6: Suppose the upper flag falls and the lower flag stays high. The status then shows protect-pending (1), and write-protect rises exactly 3+`DEB_CYC`+`WP_CYC` cycles after the input change.
- R7: Suppose the upper and lower flags fall together. Write-protect then rises 3+`DEB_CYC`+`FAST_CYC` cycles after the change, where `FAST_CYC` < `WP_CYC`.
- R8: While write-protect is high, the array enable, output enable and write strobe are high, `dq_oe_o` is low and `mode_o` is deselect (0), whatever the host drives.
- R9: A write that is still open at the protection deadline keeps the array write strobe low while protection is pending. The strobe is forced high from the deadline on.
- R10: Battery-select rises 3+`DEB_CYC` cycles after the switchover flag falls, with status battery (3). It falls 3+`DEB_CYC` cycles after that flag rises again.
- R11: After the upper flag returns, the status is recovery (4) and write-protect stays high. Write-protect falls, and the status returns to normal, 3+`DEB_CYC`+`RECOV_CYC` cycles after the flag change.
- R12: If the upper flag returns before the protection deadline, the status goes back to normal and write-protect never rises.
- R13: If the upper flag falls during recovery, the status returns to protected (2). A later return restarts the full recovery period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lvl_hi_i | input | 1 | Supply above upper trip point (asynchronous) |
| lvl_lo_i | input | 1 | Supply above lower trip point (asynchronous) |
| lvl_bat_i | input | 1 | Supply above battery switchover level (asynchronous) |
| host_e_n_i | input | 1 | Host chip enable, active low |
| host_g_n_i | input | 1 | Host output enable, active low |
| host_w_n_i | input | 1 | Host write enable, active low |
| arr_ce_n_o | output | 1 | Array chip enable, active low |
| arr_oe_n_o | output | 1 | Array output enable, active low |
| arr_we_n_o | output | 1 | Array write strobe, active low |
| dq_oe_o | output | 1 | Data bus drive enable toward the host |
| mode_o | output | 2 | Effective access mode code |
| wprot_o | output | 1 | Write-protect and deselect in force |
| bat_sel_o | output | 1 | Battery selected |
| state_o | output | 3 | Supervisor status code |

## Verification
A wrong supervisor state shows at once on the status code. It also shows within one cycle as a write strobe that reaches the array during protection, or as one that is cut off while protection is only pending. A timer that is off by one moves the rising or falling edge of write-protect by one cycle, so every deadline is measured to the exact cycle from the input change. A debounce or synchronizer fault shows as a different latency, or as a reaction to a dip that should have been filtered out.

// File: rtl/supply_guard_pkg.sv
// Shared types for the supply-loss write guard.
// Assumes: codes are visible at the status and mode ports, so their values are fixed.
package supply_guard_pkg;

    typedef enum logic [2:0] {
        SG_NORMAL = 3'd0,
        SG_PEND   = 3'd1,
        SG_PROT   = 3'd2,
        SG_BATT   = 3'd3,
        SG_RECOV  = 3'd4
    } sg_state_e;

    typedef enum logic [1:0] {
        MD_DESEL = 2'd0,
        MD_READ  = 2'd1,
        MD_HIZ   = 2'd2,
        MD_WRITE = 2'd3
    } sg_mode_e;

endpackage

// File: rtl/sg_level_filter.sv
// Synchronizes one asynchronous supply flag and debounces it.
// The filtered value flips only after the synchronized input has disagreed
// with it for DEB_CYC consecutive cycles.
// Assumes: DEB_CYC >= 1; reset value RST_VAL reflects a healthy supply.
module sg_level_filter #(
    parameter int   DEB_CYC = 3,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic lvl_o
);
    localparam int CW = (DEB_CYC < 2) ? 1 : $clog2(DEB_CYC + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          lvl_q;
    logic          s2;

    assign s2    = sync_q[1];
    assign lvl_o = lvl_q;

    // Two-flop synchronizer for the asynchronous flag.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= {2{RST_VAL}};
        else        sync_q <= {sync_q[0], raw_i};
    end

    // Debounce: count consecutive disagreement, flip at DEB_CYC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= RST_VAL;
            cnt_q <= '0;
        end else if (s2 == lvl_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(DEB_CYC - 1)) begin
            lvl_q <= s2;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5: a change of the filtered level must agree with the synchronized input.
    p_flip_needs_agree_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q != $past(lvl_q)) |-> ($past(s2) == lvl_q));

endmodule

// File: rtl/sg_power_fsm.sv
// Supply supervisor state machine.
// Tracks normal, protect-pending, protected, battery and recovery states and
// times the protect deadline (slow and fast fall) and the recovery hold-off.
// Assumes: inputs are already filtered; FAST_CYC < WP_CYC; all counts >= 1.
module sg_power_fsm
    import supply_guard_pkg::*;
#(
    parameter int WP_CYC    = 6250,
    parameter int FAST_CYC  = 5000,
    parameter int RECOV_CYC = 5000000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hi_i,
    input  logic      lo_i,
    input  logic      bat_i,
    output sg_state_e state_o,
    output logic      wprot_o,
    output logic      bat_sel_o
);
    localparam int TMAX = (RECOV_CYC > WP_CYC) ? RECOV_CYC : WP_CYC;
    localparam int CW   = $clog2(TMAX + 1);

    sg_state_e     state_q, state_d;
    logic [CW-1:0] tcnt_q, tcnt_d;
    logic [CW-1:0] fcnt_q, fcnt_d;

    // Next-state and timer logic.
    always_comb begin
        state_d = state_q;
        tcnt_d  = tcnt_q;
        fcnt_d  = fcnt_q;
        case (state_q)
            SG_NORMAL: begin
                if (!hi_i) begin
                    state_d = SG_PEND;
                    tcnt_d  = '0;
                    fcnt_d  = '0;
                end
            end
            SG_PEND: begin
                if (!bat_i) begin
                    state_d = SG_BATT;
                end else if (hi_i) begin
                    state_d = SG_NORMAL;
                end else if (tcnt_q == CW'(WP_CYC - 1) ||
                             (!lo_i && fcnt_q == CW'(FAST_CYC - 1))) begin
                    state_d = SG_PROT;
                end else begin
                    tcnt_d = tcnt_q + 1'b1;
                    if (!lo_i) fcnt_d = fcnt_q + 1'b1;
                end
            end
            SG_PROT: begin
                if (!bat_i) begin
                    state_d = SG_BATT;
                end else if (hi_i) begin
                    state_d = SG_RECOV;
                    tcnt_d  = '0;
                end
            end
            SG_BATT: begin
                if (bat_i) state_d = SG_PROT;
            end
            SG_RECOV: begin
                if (!bat_i)                              state_d = SG_BATT;
                else if (!hi_i)                          state_d = SG_PROT;
                else if (tcnt_q == CW'(RECOV_CYC - 1))   state_d = SG_NORMAL;
                else                                     tcnt_d  = tcnt_q + 1'b1;
            end
            default: state_d = SG_PROT;
        endcase
    end

    // State and timer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SG_NORMAL;
            tcnt_q  <= '0;
            fcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            tcnt_q  <= tcnt_d;
            fcnt_q  <= fcnt_d;
        end
    end

    assign state_o   = state_q;
    assign wprot_o   = (state_q == SG_PROT) || (state_q == SG_BATT) || (state_q == SG_RECOV);
    assign bat_sel_o = (state_q == SG_BATT);

    // R6: normal state can only stay or move to pending.
    p_pend_from_normal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SG_NORMAL) |=> (state_q == SG_NORMAL || state_q == SG_PEND));

    // R6: pending reaches protection at the slow-fall deadline.
    p_prot_at_deadline_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SG_PEND && bat_i && !hi_i && tcnt_q == CW'(WP_CYC - 1))
        |=> (state_q == SG_PROT));

    // R10: loss of the switchover flag outside normal selects the battery.
    p_bat_on_loss_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bat_i && state_q != SG_NORMAL) |=> bat_sel_o);

    // R11: recovery ends after its full count.
    p_recov_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SG_RECOV && hi_i && bat_i && tcnt_q == CW'(RECOV_CYC - 1))
        |=> (state_q == SG_NORMAL));

    // R13: a new sag during recovery falls back to protected.
    p_recov_abort_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SG_RECOV && bat_i && !hi_i) |=> (state_q == SG_PROT));

endmodule

// File: rtl/sg_bus_gate.sv
// Decodes the host strobes into an access mode and gates the array strobes.
// Under write-protect every access collapses to deselect.
// Assumes: combinational path from host pins to array pins; clk/rst_n serve checks only.
module sg_bus_gate
    import supply_guard_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     host_e_n_i,
    input  logic     host_g_n_i,
    input  logic     host_w_n_i,
    input  logic     wprot_i,
    output logic     arr_ce_n_o,
    output logic     arr_oe_n_o,
    output logic     arr_we_n_o,
    output logic     dq_oe_o,
    output sg_mode_e mode_o
);
    sg_mode_e raw_mode;
    sg_mode_e eff_mode;

    // Host strobe decode; write wins over read when W is low.
    always_comb begin
        if (host_e_n_i)      raw_mode = MD_DESEL;
        else if (!host_w_n_i) raw_mode = MD_WRITE;
        else if (!host_g_n_i) raw_mode = MD_READ;
        else                  raw_mode = MD_HIZ;
    end

    // Protection override and array strobe generation.
    always_comb begin
        eff_mode   = wprot_i ? MD_DESEL : raw_mode;
        arr_ce_n_o = (eff_mode == MD_DESEL);
        arr_we_n_o = (eff_mode != MD_WRITE);
        arr_oe_n_o = (eff_mode != MD_READ);
        dq_oe_o    = (eff_mode == MD_READ);
    end

    assign mode_o = eff_mode;

    // R8: protection blocks every array access.
    p_prot_blocks_we_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wprot_i |-> (arr_we_n_o && arr_ce_n_o && arr_oe_n_o && !dq_oe_o));

    // R4: the array write strobe needs both host E and W low.
    p_we_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !arr_we_n_o |-> (!host_e_n_i && !host_w_n_i));

    // R3: data is never driven while host W is low.
    p_no_drive_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_o |-> host_w_n_i);

endmodule

// File: rtl/supply_guard.sv
// Top of the supply-loss write guard: filters the three supply flags,
// runs the supervisor and gates the host strobes toward the array.
// Assumes: level flags are asynchronous and active high (supply above level).
module supply_guard
    import supply_guard_pkg::*;
#(
    parameter int DEB_CYC   = 3,
    parameter int WP_CYC    = 6250,
    parameter int FAST_CYC  = 5000,
    parameter int RECOV_CYC = 5000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl_hi_i,
    input  logic       lvl_lo_i,
    input  logic       lvl_bat_i,
    input  logic       host_e_n_i,
    input  logic       host_g_n_i,
    input  logic       host_w_n_i,
    output logic       arr_ce_n_o,
    output logic       arr_oe_n_o,
    output logic       arr_we_n_o,
    output logic       dq_oe_o,
    output logic [1:0] mode_o,
    output logic       wprot_o,
    output logic       bat_sel_o,
    output logic [2:0] state_o
);
    localparam int NLVL = 3;

    logic [NLVL-1:0] raw_lvl;
    logic [NLVL-1:0] flt_lvl;
    sg_state_e       state;
    sg_mode_e        mode;
    logic            wprot;

    assign raw_lvl = {lvl_bat_i, lvl_lo_i, lvl_hi_i};

    // One filter per supply flag.
    for (genvar gi = 0; gi < NLVL; gi++) begin : g_flt
        sg_level_filter #(
            .DEB_CYC (DEB_CYC),
            .RST_VAL (1'b1)
        ) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (raw_lvl[gi]),
            .lvl_o (flt_lvl[gi])
        );
    end

    sg_power_fsm #(
        .WP_CYC    (WP_CYC),
        .FAST_CYC  (FAST_CYC),
        .RECOV_CYC (RECOV_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hi_i      (flt_lvl[0]),
        .lo_i      (flt_lvl[1]),
        .bat_i     (flt_lvl[2]),
        .state_o   (state),
        .wprot_o   (wprot),
        .bat_sel_o (bat_sel_o)
    );

    sg_bus_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_e_n_i (host_e_n_i),
        .host_g_n_i (host_g_n_i),
        .host_w_n_i (host_w_n_i),
        .wprot_i    (wprot),
        .arr_ce_n_o (arr_ce_n_o),
        .arr_oe_n_o (arr_oe_n_o),
        .arr_we_n_o (arr_we_n_o),
        .dq_oe_o    (dq_oe_o),
        .mode_o     (mode)
    );

    assign wprot_o = wprot;
    assign state_o = state;
    assign mode_o  = mode;

endmodule

// File: tb/supply_guard_tb_top.sv
// Directed bench for supply_guard: one task per scenario, each checking itself.
module supply_guard_tb_top;
    localparam int DEB   = 3;
    localparam int WP    = 40;
    localparam int FAST  = 20;
    localparam int RECOV = 100;
    localparam int LAT   = 3 + DEB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi = 1'b1, lo = 1'b1, bat = 1'b1;
    logic e_n = 1'b1, g_n = 1'b1, w_n = 1'b1;
    logic ce_n, oe_n, we_n, dq_oe, wprot, bat_sel;
    logic [1:0] mode;
    logic [2:0] state;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    supply_guard #(
        .DEB_CYC (DEB), .WP_CYC (WP), .FAST_CYC (FAST), .RECOV_CYC (RECOV)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .lvl_hi_i (hi), .lvl_lo_i (lo), .lvl_bat_i (bat),
        .host_e_n_i (e_n), .host_g_n_i (g_n), .host_w_n_i (w_n),
        .arr_ce_n_o (ce_n), .arr_oe_n_o (oe_n), .arr_we_n_o (we_n),
        .dq_oe_o (dq_oe), .mode_o (mode), .wprot_o (wprot),
        .bat_sel_o (bat_sel), .state_o (state)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    // Count cycles until signal (0 wprot, 1 bat_sel) reaches the wanted level.
    task automatic measure(input int which, input logic want, output int n);
        logic v;
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
            v = (which == 0) ? wprot : bat_sel;
        end while (v !== want && n < 3000);
    endtask

    task automatic host(input logic e, input logic g, input logic w);
        e_n = e; g_n = g; w_n = w;
        #1;
    endtask

    task automatic go_protected();
        int n;
        hi = 1'b0;
        measure(0, 1'b1, n);
    endtask

    task automatic back_to_normal();
        int n;
        hi = 1'b1; lo = 1'b1; bat = 1'b1;
        for (int i = 0; i < 400 && state != 3'd0; i++) cyc(1);
        cyc(2);
    endtask

    task automatic t_reset();
        chk(state == 3'd0, "R1", "state after reset", state, 0);
        chk(wprot == 1'b0 && bat_sel == 1'b0, "R1", "wprot/bat_sel", {wprot, bat_sel}, 0);
        host(1'b0, 1'b0, 1'b1);
        chk(oe_n == 1'b0 && dq_oe == 1'b1, "R1", "read passes after reset", {oe_n, dq_oe}, 1);
        host(1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_decode();
        host(1'b1, 1'b0, 1'b0);
        chk(mode == 2'd0 && ce_n && we_n && !dq_oe, "R2", "deselect", mode, 0);
        host(1'b0, 1'b1, 1'b0);
        chk(mode == 2'd3 && !ce_n && !we_n, "R2", "write", mode, 3);
        host(1'b0, 1'b0, 1'b1);
        chk(mode == 2'd1 && dq_oe && !oe_n && we_n, "R2", "read", mode, 1);
        host(1'b0, 1'b1, 1'b1);
        chk(mode == 2'd2 && !dq_oe && oe_n && !ce_n, "R2", "outputs off", mode, 2);
        // R4: W falls first, E later: write opens at E, closes when W rises first.
        host(1'b1, 1'b1, 1'b0);
        chk(we_n == 1'b1, "R4", "W low alone", we_n, 1);
        host(1'b0, 1'b1, 1'b0);
        chk(we_n == 1'b0, "R4", "both low", we_n, 0);
        host(1'b0, 1'b1, 1'b1);
        chk(we_n == 1'b1, "R4", "W rises first", we_n, 1);
        host(1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_read_w_low();
        host(1'b0, 1'b0, 1'b1);
        cyc(1);
        host(1'b0, 1'b0, 1'b0);
        chk(dq_oe == 1'b0 && mode == 2'd3 && we_n == 1'b0, "R3", "W low in read", dq_oe, 0);
        host(1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_glitch();
        int bad = 0;
        hi = 1'b0;
        cyc(DEB - 1);
        hi = 1'b1;
        for (int i = 0; i < 20; i++) begin
            cyc(1);
            if (state != 3'd0) bad++;
        end
        chk(bad == 0, "R5", "short dip ignored", bad, 0);
    endtask

    task automatic t_short_dip();
        int seen_pend = 0;
        int seen_prot = 0;
        hi = 1'b0;
        cyc(15);
        hi = 1'b1;
        for (int i = 0; i < 80; i++) begin
            if (state == 3'd1) seen_pend++;
            if (wprot) seen_prot++;
            cyc(1);
        end
        chk(seen_pend > 0, "R12", "pending seen", seen_pend, 1);
        chk(seen_prot == 0 && state == 3'd0, "R12", "no protection", seen_prot, 0);
    endtask

    task automatic t_slow_fall();
        int n;
        hi = 1'b0;
        cyc(LAT + 2);
        chk(state == 3'd1, "R6", "pending status", state, 1);
        measure(0, 1'b1, n);
        n = n + LAT + 2;
        chk(n == LAT + WP, "R6", "protect latency", n, LAT + WP);
        chk(state == 3'd2, "R6", "protected status", state, 2);
        host(1'b0, 1'b1, 1'b0);
        chk(we_n && ce_n && mode == 2'd0, "R8", "write blocked", {we_n, ce_n}, 3);
        host(1'b0, 1'b0, 1'b1);
        chk(!dq_oe && oe_n, "R8", "read blocked", dq_oe, 0);
        host(1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_battery();
        int n;
        lo = 1'b0; bat = 1'b0;
        measure(1, 1'b1, n);
        chk(n == LAT, "R10", "battery select latency", n, LAT);
        chk(state == 3'd3 && wprot, "R10", "battery status", state, 3);
        lo = 1'b1; bat = 1'b1;
        measure(1, 1'b0, n);
        chk(n == LAT, "R10", "battery release latency", n, LAT);
    endtask

    task automatic t_recovery();
        int n;
        hi = 1'b1;
        cyc(LAT + 10);
        chk(state == 3'd4 && wprot, "R11", "recovery status", state, 4);
        measure(0, 1'b0, n);
        n = n + LAT + 10;
        chk(n == LAT + RECOV, "R11", "recovery length", n, LAT + RECOV);
        chk(state == 3'd0, "R11", "normal after recovery", state, 0);
    endtask

    task automatic t_recov_abort();
        int n;
        go_protected();
        hi = 1'b1;
        cyc(LAT + 30);
        hi = 1'b0;
        cyc(LAT);
        chk(state == 3'd2, "R13", "sag during recovery", state, 2);
        hi = 1'b1;
        measure(0, 1'b0, n);
        chk(n == LAT + RECOV, "R13", "recovery restarted", n, LAT + RECOV);
    endtask

    task automatic t_fast_fall();
        int n;
        hi = 1'b0; lo = 1'b0;
        measure(0, 1'b1, n);
        chk(n == LAT + FAST, "R7", "fast protect latency", n, LAT + FAST);
        back_to_normal();
    endtask

    task automatic t_write_cut();
        int n;
        host(1'b0, 1'b1, 1'b0);
        hi = 1'b0;
        cyc(LAT + 5);
        chk(state == 3'd1 && we_n == 1'b0, "R9", "write open while pending", we_n, 0);
        measure(0, 1'b1, n);
        chk(we_n == 1'b1, "R9", "write cut at deadline", we_n, 1);
        host(1'b1, 1'b1, 1'b1);
        back_to_normal();
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_decode();
        t_read_w_low();
        t_glitch();
        t_short_dip();
        t_slow_fall();
        t_battery();
        t_recovery();
        t_recov_abort();
        t_fast_fall();
        t_write_cut();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule